// File: doc/BRIEF.md
# Indexed Word-Store Execution Unit

This block carries out the single store-word instruction of a small coprocessor that has eight 16-bit general registers. It takes a 16-bit instruction word, reads the source, base and index registers through three combinational register-file read ports, and forms the target address. It then raises a word write request toward memory and holds it until memory acknowledges. Four addressing forms are supported:

- base plus a 5-bit unsigned immediate;
- base plus index;
- base plus index followed by an index step of +2;
- index stepped by −2 first, then base plus the stepped index.

When a form modifies the index, the new index value goes back to the register file through a writeback port. That writeback fires in the same cycle as the memory acknowledge. An instruction is accepted only while the unit is idle. An encoding the unit does not recognise produces a one-cycle illegal pulse and has no other effect.

Top module: `wstore_unit`

## Requirements
- R1: With instr[15:11] = 01011, the unit writes the source register (field instr[10:8]) to address base register (field instr[7:5]) plus instr[4:0] zero-extended. It performs no index writeback.
- R2: With instr[15:11] = 01111 and instr[1:0] = 00, the address is base plus the index register (field instr[4:2]). It performs no index writeback.
- R3: With instr[15:11] = 01111 and instr[1:0] = 01, the address is base plus the index value before the update. The writeback carries the index plus 2.
- R4: With instr[15:11] = 01111 and instr[1:0] = 10, the address is base plus (index − 2). The writeback carries index − 2.
- R5: When the source and index fields name the same register, the data written is that register's value before any index update.
- R6: Register 0 reads as zero for source, base and index. A writeback aimed at register 0 is suppressed (wb_en stays low).
- R7: All address and index arithmetic wraps modulo 2^16, and mem_be is 11 whenever mem_req is high.
- R8: An instruction accepted at a clock edge (instr_valid and instr_ready both high) drives mem_req high from that edge on. mem_req, mem_addr and mem_wdata then stay unchanged until the cycle in which mem_ack is high. instr_ready is low whenever mem_req is high.
- R9: wb_en is high only in the cycle where mem_req and mem_ack are both high, and only for the two index-modifying forms. One edge after the acknowledge, mem_req is low and instr_ready is high.
- R10: An accepted instruction with instr[1:0] = 11 under opcode 01111, or with any other value of instr[15:11], raises illegal for exactly the following cycle. It produces no mem_req and no wb_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction word present |
| instr | input | 16 | Instruction word |
| instr_ready | output | 1 | Unit idle, can accept |
| rf_sel_src | output | 3 | Register-file read address, source |
| rf_sel_base | output | 3 | Register-file read address, base |
| rf_sel_idx | output | 3 | Register-file read address, index |
| rf_val_src | input | 16 | Source register value |
| rf_val_base | input | 16 | Base register value |
| rf_val_idx | input | 16 | Index register value |
| mem_req | output | 1 | Write request |
| mem_addr | output | 16 | Write address |
| mem_wdata | output | 16 | Write data |
| mem_be | output | 2 | Byte strobes |
| mem_ack | input | 1 | Memory accepts the write |
| wb_en | output | 1 | Index writeback strobe |
| wb_sel | output | 3 | Writeback register |
| wb_data | output | 16 | Writeback value |
| illegal | output | 1 | Unrecognised encoding pulse |

## Verification
A wrongly captured address, data word or index value is visible on mem_addr, mem_wdata or wb_data one edge after acceptance. It stays visible for as long as acknowledge is withheld, and the bench varies that hold time. A stuck busy state shows as instr_ready staying low one edge after the acknowledge. A lost illegal decode shows as a request appearing where the illegal pulse should be. The sweeps cover every source, base and index combination, including coincident registers and register 0, in all four forms.

// File: rtl/wstore_pkg.sv
package wstore_pkg;
    localparam int SEL_W = 3;
    localparam int OFFS_W = 5;
    localparam logic [4:0] OP_OFFS = 5'b01011;
    localparam logic [4:0] OP_INDEX = 5'b01111;

    typedef enum logic [2:0] {
        K_OFFS,
        K_IDX,
        K_POST,
        K_PRE,
        K_BAD
    } kind_e;

    typedef struct packed {
        kind_e             kind;
        logic [SEL_W-1:0]  src;
        logic [SEL_W-1:0]  base;
        logic [SEL_W-1:0]  idx;
        logic [OFFS_W-1:0] offs;
    } dec_t;
endpackage

// File: rtl/wstore_decode.sv
module wstore_decode
    import wstore_pkg::*;
(
    input  logic [15:0] instr,
    output dec_t        dec
);
    always_comb begin
        dec.src  = instr[10:8];
        dec.base = instr[7:5];
        dec.idx  = instr[4:2];
        dec.offs = instr[4:0];
        if (instr[15:11] == OP_OFFS) begin
            dec.kind = K_OFFS;
        end else if (instr[15:11] == OP_INDEX) begin
            case (instr[1:0])
                2'b00:   dec.kind = K_IDX;
                2'b01:   dec.kind = K_POST;
                2'b10:   dec.kind = K_PRE;
                default: dec.kind = K_BAD;
            endcase
        end else begin
            dec.kind = K_BAD;
        end
    end
endmodule

// File: rtl/wstore_agen.sv
module wstore_agen
    import wstore_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int STEP   = 2
) (
    input  kind_e              kind,
    input  logic [DATA_W-1:0]  base_v,
    input  logic [DATA_W-1:0]  idx_v,
    input  logic [OFFS_W-1:0]  offs,
    input  logic [SEL_W-1:0]   idx_sel,
    output logic [DATA_W-1:0]  addr,
    output logic [DATA_W-1:0]  idx_new,
    output logic               wb_req
);
    localparam logic [DATA_W-1:0] STEP_V = DATA_W'(STEP);

    logic [DATA_W-1:0] disp;

    always_comb begin
        idx_new = idx_v;
        disp    = idx_v;
        wb_req  = 1'b0;
        case (kind)
            K_OFFS: disp = DATA_W'(offs);
            K_POST: begin
                idx_new = idx_v + STEP_V;
                wb_req  = (idx_sel != '0);
            end
            K_PRE: begin
                idx_new = idx_v - STEP_V;
                disp    = idx_new;
                wb_req  = (idx_sel != '0);
            end
            default: ;
        endcase
        addr = base_v + disp;
    end
endmodule

// File: rtl/wstore_unit.sv
module wstore_unit
    import wstore_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int STEP   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 instr_valid,
    input  logic [15:0]          instr,
    output logic                 instr_ready,
    output logic [SEL_W-1:0]     rf_sel_src,
    output logic [SEL_W-1:0]     rf_sel_base,
    output logic [SEL_W-1:0]     rf_sel_idx,
    input  logic [DATA_W-1:0]    rf_val_src,
    input  logic [DATA_W-1:0]    rf_val_base,
    input  logic [DATA_W-1:0]    rf_val_idx,
    output logic                 mem_req,
    output logic [DATA_W-1:0]    mem_addr,
    output logic [DATA_W-1:0]    mem_wdata,
    output logic [DATA_W/8-1:0]  mem_be,
    input  logic                 mem_ack,
    output logic                 wb_en,
    output logic [SEL_W-1:0]     wb_sel,
    output logic [DATA_W-1:0]    wb_data,
    output logic                 illegal
);
    localparam int BE_W = DATA_W / 8;

    typedef struct packed {
        logic              busy;
        logic              bad;
        logic [DATA_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              wb_req;
        logic [SEL_W-1:0]  wb_sel;
        logic [DATA_W-1:0] wb_data;
    } st_t;

    st_t st_d, st_q;
    dec_t dec;
    logic [DATA_W-1:0] src_v, base_v, idx_v;
    logic [DATA_W-1:0] ag_addr, ag_idx_new;
    logic ag_wb_req;

    wstore_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    assign rf_sel_src  = dec.src;
    assign rf_sel_base = dec.base;
    assign rf_sel_idx  = dec.idx;

    // register 0 is hardwired to zero on every read path
    assign src_v  = (dec.src  == '0) ? '0 : rf_val_src;
    assign base_v = (dec.base == '0) ? '0 : rf_val_base;
    assign idx_v  = (dec.idx  == '0) ? '0 : rf_val_idx;

    wstore_agen #(.DATA_W(DATA_W), .STEP(STEP)) u_agen (
        .kind    (dec.kind),
        .base_v  (base_v),
        .idx_v   (idx_v),
        .offs    (dec.offs),
        .idx_sel (dec.idx),
        .addr    (ag_addr),
        .idx_new (ag_idx_new),
        .wb_req  (ag_wb_req)
    );

    always_comb begin
        st_d     = st_q;
        st_d.bad = 1'b0;
        if (!st_q.busy) begin
            if (instr_valid) begin
                if (dec.kind == K_BAD) begin
                    st_d.bad = 1'b1;
                end else begin
                    st_d.busy    = 1'b1;
                    st_d.addr    = ag_addr;
                    st_d.wdata   = src_v;
                    st_d.wb_req  = ag_wb_req;
                    st_d.wb_sel  = dec.idx;
                    st_d.wb_data = ag_idx_new;
                end
            end
        end else if (mem_ack) begin
            st_d.busy   = 1'b0;
            st_d.wb_req = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign instr_ready = !st_q.busy;
    assign mem_req     = st_q.busy;
    assign mem_addr    = st_q.addr;
    assign mem_wdata   = st_q.wdata;
    assign mem_be      = st_q.busy ? {BE_W{1'b1}} : '0;
    assign wb_en       = st_q.busy && mem_ack && st_q.wb_req;
    assign wb_sel      = st_q.wb_sel;
    assign wb_data     = st_q.wb_data;
    assign illegal     = st_q.bad;

    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_wdata));
    a_r8_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !instr_ready);
    a_r8_accept_req: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && instr_ready && (dec.kind != K_BAD) |=> mem_req);
    a_r9_wb_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> mem_req && mem_ack);
    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack |=> !mem_req && instr_ready);
    a_r6_no_zero_wb: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> wb_sel != '0);
    a_r7_full_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_be == {BE_W{1'b1}});
    a_r10_bad_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !mem_req && !wb_en);
    a_r10_bad_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && instr_ready && (dec.kind == K_BAD) |=> illegal && !mem_req);
endmodule

// File: tb/wstore_unit_tb.sv
`timescale 1ns/1ps
module wstore_unit_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic instr_valid = 1'b0;
    logic [15:0] instr = '0;
    logic instr_ready;
    logic [2:0] rf_sel_src, rf_sel_base, rf_sel_idx;
    logic [15:0] rf_val_src, rf_val_base, rf_val_idx;
    logic mem_req;
    logic [15:0] mem_addr, mem_wdata;
    logic [1:0] mem_be;
    logic mem_ack = 1'b0;
    logic wb_en;
    logic [2:0] wb_sel;
    logic [15:0] wb_data;
    logic illegal;

    logic [15:0] regs [8];
    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    always_comb begin
        rf_val_src  = regs[rf_sel_src];
        rf_val_base = regs[rf_sel_base];
        rf_val_idx  = regs[rf_sel_idx];
    end

    wstore_unit u_dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .instr_ready(instr_ready), .rf_sel_src(rf_sel_src), .rf_sel_base(rf_sel_base),
        .rf_sel_idx(rf_sel_idx), .rf_val_src(rf_val_src), .rf_val_base(rf_val_base),
        .rf_val_idx(rf_val_idx), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack), .wb_en(wb_en),
        .wb_sel(wb_sel), .wb_data(wb_data), .illegal(illegal)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] rv(input int r);
        return (r == 0) ? 16'h0 : regs[r];
    endfunction

    function automatic logic [15:0] seedval(input int r, input int t);
        logic [15:0] v;
        v = 16'(r * 16'h3A7 + t * 16'h1F1F) ^ 16'hC3F0;
        if ((t % 5) == 0) v = 16'hFFFF - 16'(r);
        if ((t % 7) == 0) v = 16'(r);
        return v;
    endfunction

    task automatic load_regs(input int t);
        for (int r = 0; r < 8; r++) regs[r] = seedval(r, t);
    endtask

    task automatic do_store(input logic [15:0] iw, input logic [15:0] ea,
                            input logic [15:0] ed, input bit ewb, input logic [2:0] esel,
                            input logic [15:0] ewd, input string req, input int hold);
        @(negedge clk);
        instr = iw;
        instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        chk(mem_req === 1'b1, "R8 req", 32'(mem_req), 1);
        chk(instr_ready === 1'b0, "R8 ready", 32'(instr_ready), 0);
        chk(mem_addr === ea, {req, " addr"}, 32'(mem_addr), 32'(ea));
        chk(mem_wdata === ed, {req, " data R5"}, 32'(mem_wdata), 32'(ed));
        chk(mem_be === 2'b11, "R7 be", 32'(mem_be), 3);
        chk(wb_en === 1'b0, "R9 early wb", 32'(wb_en), 0);
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(mem_req === 1'b1 && mem_addr === ea && mem_wdata === ed, "R8 hold",
                32'(mem_addr), 32'(ea));
        end
        mem_ack = 1'b1;
        #0.5;
        chk(wb_en === ewb, {req, " R6 wb_en"}, 32'(wb_en), 32'(ewb));
        if (ewb) begin
            chk(wb_sel === esel, {req, " wb_sel"}, 32'(wb_sel), 32'(esel));
            chk(wb_data === ewd, {req, " wb_data"}, 32'(wb_data), 32'(ewd));
        end
        @(negedge clk);
        mem_ack = 1'b0;
        if (ewb) regs[esel] = ewd;
        chk(mem_req === 1'b0 && instr_ready === 1'b1, "R9 release",
            32'({mem_req, instr_ready}), 1);
    endtask

    task automatic do_bad(input logic [15:0] iw);
        @(negedge clk);
        instr = iw;
        instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        chk(illegal === 1'b1, "R10 pulse", 32'(illegal), 1);
        chk(mem_req === 1'b0 && wb_en === 1'b0, "R10 quiet", 32'({mem_req, wb_en}), 0);
        @(negedge clk);
        chk(illegal === 1'b0 && mem_req === 1'b0, "R10 one cycle",
            32'({illegal, mem_req}), 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        load_regs(1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(instr_ready === 1'b1 && mem_req === 1'b0 && wb_en === 1'b0 && illegal === 1'b0,
            "reset state", 32'({instr_ready, mem_req, wb_en, illegal}), 32'h8);

        // R1: offset form, all src/base and all 32 offsets
        for (int s = 0; s < 8; s++)
            for (int b = 0; b < 8; b++)
                for (int o = 0; o < 32; o++) begin
                    load_regs(s * 64 + b * 8 + o);
                    do_store({5'b01011, 3'(s), 3'(b), 5'(o)}, rv(b) + 16'(o), rv(s),
                             1'b0, 3'd0, 16'd0, "R1", o % 3);
                end

        // R2 R3 R4 R5 R6 R7: index forms over every register triple
        for (int m = 0; m < 3; m++)
            for (int s = 0; s < 8; s++)
                for (int b = 0; b < 8; b++)
                    for (int i = 0; i < 8; i++) begin
                        logic [15:0] iv, nv, ea;
                        string rq;
                        load_regs(m * 512 + s * 64 + b * 8 + i + 3);
                        iv = rv(i);
                        nv = (m == 1) ? iv + 16'd2 : (m == 2) ? iv - 16'd2 : iv;
                        ea = rv(b) + ((m == 2) ? nv : iv);
                        rq = (m == 0) ? "R2" : (m == 1) ? "R3" : "R4";
                        do_store({5'b01111, 3'(s), 3'(b), 3'(i), 2'(m)}, ea, rv(s),
                                 (m != 0) && (i != 0), 3'(i), nv, rq, (s + i) % 3);
                    end

        // R10: reserved index code and foreign opcodes
        for (int k = 0; k < 8; k++) do_bad({5'b01111, 3'(k), 3'(7 - k), 3'(k), 2'b11});
        do_bad(16'h0000);
        do_bad(16'hFFFF);
        do_bad({5'b01010, 11'h3FF});

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule